// File: doc/BRIEF.md
# Transmit Pair-Lane Word Deserializer

This block turns a serial transmit stream into 16-bit converter words. Each channel has a lane two bits wide. The lane is sampled once per bit-cycle, on a one-clock strobe `ph_en`. The strobe stands for the falling half of a divided bit clock. Eight samples make one word, and the most significant pair comes first.

A marker pulse, `frame_mark`, is taken together with the strobe. It tells the block that the sample in that cycle carries bits [15:14] of the first word of a frame. Every channel shares one framing sequencer, so all channels assemble their words in lockstep. A completed word is presented with a one-clock valid pulse.

Per frame, the block accepts two words in full-rate mode and four words in half-rate mode. After the last word of a frame it ignores the lane until the next marker.

The source is a free-running converter lane that cannot be paused. For that reason the output stream is valid-only and has no ready input. The consumer must take every word in the clock cycle in which `word_vld` is high. There is no back-pressure.

Top module: `tx_word_deser`

## Requirements
- R1: While reset is held, and after it is released, `word_vld` is 0 and `word_out` is all zeros until the first word completes.
- R2: The eight pairs of a word are packed MSB first. Pair k (k = 0..7, pair 0 being the first strobed sample of the word) lands in bits [15-2k:14-2k] of that channel's word, with lane bit 1 going to the higher bit of the two.
- R3: `word_vld` is high for exactly one clock. That clock is the one right after the clock edge at which the eighth pair was strobed, and `word_out` carries the new word in that same clock.
- R4: `word_out` holds its value in every clock in which no new word completes.
- R5: Before the first marker after reset, strobed lane data produces no word.
- R6: A frame holds 2 words when `rate_mode` = 0 and 4 words when `rate_mode` = 1. Strobed pairs after the last word of a frame produce no word, and `word_out` keeps its value until a marker arrives.
- R7: A marker that arrives in the middle of a word discards the partial word, and its own sample becomes pair 0 of a new word. This holds even when the marker falls on the eighth pair position.
- R8: The lane and the marker have no effect in clocks in which `ph_en` is 0.
- R9: `rate_mode` is taken only together with a marker. A change in the middle of a frame takes effect at the next marker.
- R10: Channel c uses lane bits [2c+1:2c] and outputs bits [16c+15:16c]. All channels share the same framing and the same valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ph_en | input | 1 | Bit-cycle sample strobe (falling half of the divided clock) |
| frame_mark | input | 1 | Start-of-frame marker, taken only with `ph_en` |
| rate_mode | input | 1 | 0: two words per frame; 1: four words per frame |
| lane_in | input | 2*NUM_CH | Transmit lanes, two bits per channel |
| word_out | output | 16*NUM_CH | Assembled words, 16 bits per channel |
| word_vld | output | 1 | One-clock pulse for each completed word |

## Verification
The hardest situations to reach are those in which the framing state differs from what the lane contents suggest:
- a marker landing on the eighth pair of a word, where a word would otherwise have completed;
- a mode change in the middle of a frame, which must not change that frame's word count.

The bench reaches both by calling one pair-level task with chosen pair counts and marker positions. It also holds the strobe low while it toggles the lane and the marker. In each case it watches at the ports whether a valid pulse appears and what word it carries.

// File: rtl/afe_txdes_pkg.sv
package afe_txdes_pkg;
  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_HALF = 1'b1
  } rate_mode_e;

  localparam int unsigned MAX_WORDS_PER_FRAME = 4;
endpackage

// File: rtl/txdes_framer.sv
module txdes_framer
  import afe_txdes_pkg::*;
#(
  parameter int unsigned PAIRS     = 8,
  parameter int unsigned MAX_WORDS = MAX_WORDS_PER_FRAME
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ph_en,
  input  logic frame_mark,
  input  logic rate_mode,
  output logic shift_o,
  output logic restart_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int unsigned IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAIRS - 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(MAX_WORDS / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_HALF = IDX_W'(MAX_WORDS - 1);

  logic [CNT_W-1:0] pair_cnt;
  logic [IDX_W-1:0] word_idx;
  logic [IDX_W-1:0] idx_last;
  logic             active;
  logic             restart;
  logic             step;
  logic             wrap;

  assign restart = ph_en & frame_mark;
  assign step    = ph_en & active & ~frame_mark;
  assign wrap    = step & (pair_cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_cnt <= '0;
      word_idx <= '0;
      idx_last <= IDX_FULL;
      active   <= 1'b0;
    end else if (restart) begin
      pair_cnt <= CNT_W'(1);
      word_idx <= '0;
      active   <= 1'b1;
      idx_last <= (rate_mode_e'(rate_mode) == MODE_HALF) ? IDX_HALF : IDX_FULL;
    end else if (wrap) begin
      pair_cnt <= '0;
      word_idx <= word_idx + 1'b1;
      if (word_idx == idx_last) active <= 1'b0;
    end else if (step) begin
      pair_cnt <= pair_cnt + 1'b1;
    end
  end

  assign shift_o   = restart | step;
  assign restart_o = restart;
  assign done_o    = wrap;

  // R8: nothing moves in clocks without the strobe
  p_no_strobe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_en |=> ($stable(pair_cnt) && $stable(word_idx) && $stable(active)));

  // R7: a marker always restarts at the second pair position
  p_mark_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_en && frame_mark) |=> (pair_cnt == CNT_W'(1) && word_idx == '0 && active));

  // R6: after the last word of a frame the sequencer goes idle
  p_frame_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && word_idx == idx_last) |=> !active);
endmodule

// File: rtl/txdes_lane.sv
module txdes_lane #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAIR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic              restart,
  input  logic              done,
  input  logic [PAIR_W-1:0] lane,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned SR_W = WORD_W - PAIR_W;

  logic [SR_W-1:0]   sr;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (restart) begin
      sr <= {{(SR_W-PAIR_W){1'b0}}, lane};
    end else if (shift) begin
      sr <= {sr[SR_W-PAIR_W-1:0], lane};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (done) word_q <= {sr, lane};
  end

  assign word = word_q;

  // R4: output word only changes at a completed word
  p_word_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(word_q));
endmodule

// File: rtl/tx_word_deser.sv
module tx_word_deser
  import afe_txdes_pkg::*;
#(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned PAIR_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ph_en,
  input  logic                       frame_mark,
  input  logic                       rate_mode,
  input  logic [NUM_CH*PAIR_W-1:0]   lane_in,
  output logic [NUM_CH*WORD_W-1:0]   word_out,
  output logic                       word_vld
);
  localparam int unsigned PAIRS = WORD_W / PAIR_W;

  logic shift, restart, done;
  logic vld_q;

  txdes_framer #(
    .PAIRS     (PAIRS),
    .MAX_WORDS (MAX_WORDS_PER_FRAME)
  ) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph_en      (ph_en),
    .frame_mark (frame_mark),
    .rate_mode  (rate_mode),
    .shift_o    (shift),
    .restart_o  (restart),
    .done_o     (done)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    txdes_lane #(
      .WORD_W (WORD_W),
      .PAIR_W (PAIR_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift   (shift),
      .restart (restart),
      .done    (done),
      .lane    (lane_in[c*PAIR_W +: PAIR_W]),
      .word    (word_out[c*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= done;
  end

  assign word_vld = vld_q;

  // R3: valid is a single-clock pulse
  p_vld_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R8: a pulse only follows a strobed clock
  p_vld_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_en |=> !vld_q);
endmodule

// File: tb/tx_word_deser_bench.sv
module tx_word_deser_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ph_en = 1'b0;
  logic        frame_mark = 1'b0;
  logic        rate_mode = 1'b0;
  logic [3:0]  lane_in = '0;
  logic [31:0] word_out;
  logic        word_vld;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  localparam logic [15:0] XM = 16'hA5C3;
  // {mode, w0, w1, w2, w3}; mode 0 uses w0,w1 only
  localparam logic [64:0] FRAMES [0:5] = '{
    {1'b0, 16'h8001, 16'h7FFE, 16'h0000, 16'h0000},
    {1'b1, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0},
    {1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000},
    {1'b1, 16'hC000, 16'h0003, 16'h3C3C, 16'hE4E4},
    {1'b1, 16'h0F0F, 16'hF0F0, 16'h1B1B, 16'h2D2D},
    {1'b0, 16'hAAAA, 16'h5555, 16'h0000, 16'h0000}
  };

  tx_word_deser u_tx_word_deser (
    .clk(clk), .rst_n(rst_n), .ph_en(ph_en), .frame_mark(frame_mark),
    .rate_mode(rate_mode), .lane_in(lane_in), .word_out(word_out), .word_vld(word_vld)
  );

  always #5 clk = ~clk;

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // sends n pairs of a word (ch0 word a, ch1 word b), marker on the first pair if mk
  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic mk, input int n,
                      output int nv, output logic [31:0] got, output int pos);
    nv = 0; got = '0; pos = -1;
    for (int p = 0; p < n; p++) begin
      lane_in    = {b[15-2*p -: 2], a[15-2*p -: 2]};
      ph_en      = 1'b1;
      frame_mark = mk && (p == 0);
      @(negedge clk);
      if (word_vld) begin nv++; got = word_out; pos = p; end
      ph_en = 1'b0; frame_mark = 1'b0;
      @(negedge clk);
      if (word_vld) nv++;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int nv, pos;
    logic [31:0] got, held;
    logic [15:0] w;
    int nw;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(word_vld == 1'b0 && word_out == '0, "R1 reset", {word_vld, word_out[30:0]}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(word_vld == 1'b0 && word_out == '0, "R1 after release", word_out, 0);

    // R5: data before any marker is ignored
    send(16'h1357, 16'h2468, 1'b0, 8, nv, got, pos);
    send(16'h1357, 16'h2468, 1'b0, 8, nv, got, pos);
    check(nv == 0 && word_out == '0, "R5 no marker yet", nv, 0);

    // table walk: R2, R3, R6, R10
    for (int f = 0; f < 6; f++) begin
      rate_mode = FRAMES[f][64];
      nw = FRAMES[f][64] ? 4 : 2;
      for (int k = 0; k < nw; k++) begin
        w = FRAMES[f][63-16*k -: 16];
        send(w, w ^ XM, k == 0, 8, nv, got, pos);
        check(nv == 1 && pos == 7, "R3 single pulse after 8th pair", nv*100+pos, 107);
        check(got == {w ^ XM, w}, "R2/R10 word contents", got, {w ^ XM, w});
      end
    end

    // R6: pairs after the last word of a frame are ignored
    held = word_out;
    send(16'hBEEF, 16'hCAFE, 1'b0, 8, nv, got, pos);
    send(16'hBEEF, 16'hCAFE, 1'b0, 8, nv, got, pos);
    check(nv == 0 && word_out == held, "R6/R4 idle after frame", word_out, held);

    // R7: marker mid-word discards partial word
    rate_mode = 1'b0;
    send(16'hFFFF, 16'hFFFF, 1'b1, 3, nv, got, pos);
    send(16'h4321, 16'h8765, 1'b1, 8, nv, got, pos);
    check(nv == 1 && got == 32'h8765_4321, "R7 mid-word marker", got, 32'h8765_4321);

    // R7: marker at the 8th pair position
    send(16'h0001, 16'h0002, 1'b0, 7, nv, got, pos);
    check(nv == 0, "R7 no word before 8th", nv, 0);
    send(16'h6E6E, 16'h9191, 1'b1, 8, nv, got, pos);
    check(nv == 1 && got == 32'h9191_6E6E, "R7 marker on 8th pair", got, 32'h9191_6E6E);

    // R8: lane and marker ignored without strobe
    send(16'h3CA5, 16'h5A3C, 1'b1, 4, nv, got, pos);
    lane_in = 4'hF; frame_mark = 1'b1; ph_en = 1'b0;
    repeat (3) @(negedge clk);
    lane_in = 4'h0;
    @(negedge clk);
    frame_mark = 1'b0;
    check(word_vld == 1'b0, "R8 no pulse without strobe", word_vld, 0);
    begin
      logic [15:0] a, b;
      a = 16'h3CA5; b = 16'h5A3C;
      nv = 0;
      for (int p = 4; p < 8; p++) begin
        lane_in = {b[15-2*p -: 2], a[15-2*p -: 2]}; ph_en = 1'b1;
        @(negedge clk);
        if (word_vld) begin nv++; got = word_out; end
        ph_en = 1'b0;
        @(negedge clk);
      end
    end
    check(nv == 1 && got == 32'h5A3C_3CA5, "R8 word intact", got, 32'h5A3C_3CA5);

    // R9: mode change mid-frame takes effect at next marker
    rate_mode = 1'b0;
    send(16'h1111, 16'h2222, 1'b1, 8, nv, got, pos);
    rate_mode = 1'b1;
    send(16'h3333, 16'h4444, 1'b0, 8, nv, got, pos);
    check(nv == 1, "R9 second word of frame", nv, 1);
    send(16'h5555, 16'h6666, 1'b0, 8, nv, got, pos);
    check(nv == 0, "R9 old mode still governs frame", nv, 0);
    nw = 0;
    for (int k = 0; k < 4; k++) begin
      send(16'h7000 + 16'(k), 16'h0700, k == 0, 8, nv, got, pos);
      nw += nv;
    end
    check(nw == 4 && got == 32'h0700_7003, "R9 new mode after marker", got, 32'h0700_7003);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule